// File: doc/BRIEF.md
# Burst-Mode Green-Mode Controller

This block watches the stream of switching events reported by the drain-sense comparator of a synchronous-rectifier controller. It decides when the primary converter has gone into deep burst operation and moves the controller into a low-power green mode. While that mode is active, the single output flag disables both gate channels and the offset current sources.

Entry takes two steps. First, a quiet interval with no switching must pass. Then a separate settle (debounce) interval must also pass with no switching. Any edge during either step restarts the process.

Once in green mode, the block leaves it in one of two ways:
- a switching burst begins after only a short idle gap, or
- a run of consecutive cycles shows a normal switching period.

A variant select picks between a high-frequency and a low-frequency set of timings. All timings are parameters counted in clock cycles. The defaults assume a 50 MHz clock: quiet 80/160 µs, settle 180/320 µs, short-gap limit 40/80 µs, normal period 20/40 µs.

Top module: `gm_burst_green`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `green_mode` is 0. Reset counts as a switching event for the idle timing.
- R2: The quiet interval alone never asserts `green_mode`. With `lf_sel` = 0 and no edges, `green_mode` is still 0 QUIET_HF cycles after the last edge.
- R3: Let `sw_edge` be sampled high at clock edge e, with no further edges. `green_mode` goes high at clock edge e + QUIET + SETTLE and not before. QUIET/SETTLE are the `_HF` values when `lf_sel` = 0 and the `_LF` values when `lf_sel` = 1.
- R4: An edge sampled at any clock before the entry point of R3, including exactly at it, keeps `green_mode` at 0. The whole quiet-plus-settle interval then restarts from that edge.
- R5: The gap of an edge is the number of clocks since the previous edge. In green mode, an edge with gap ≥ NORM and gap < BURST clears `green_mode` at that clock edge. A gap equal to NORM qualifies.
- R6: In green mode, an edge with gap < NORM counts as a normal cycle. The RUN_LEN-th (default 7) consecutive normal cycle clears `green_mode`; the earlier ones leave it set.
- R7: In green mode, an edge with gap ≥ BURST (a gap equal to BURST included) leaves `green_mode` set and resets the normal-cycle count to zero.
- R8: The idle timer saturates. `green_mode` stays set through an idle far longer than any threshold, and a following edge after such an idle is treated as a long gap.
- R9: `lf_sel` = 1 applies the low-frequency value of every threshold (quiet, settle, short gap, normal period); `lf_sel` = 0 applies the high-frequency ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_edge | input | 1 | One-cycle pulse per drain switching event |
| lf_sel | input | 1 | Timing set: 0 high-frequency, 1 low-frequency; held stable outside reset |
| green_mode | output | 1 | 1 while in green mode; gates off both channels and the offset current |

## Verification
Two of the block's functions can fall in the same cycle.

**Settle expiry and a switching edge.** The end of the settle interval and an arriving switching edge can coincide. The bench places an edge exactly QUIET + SETTLE clocks after the previous one. It then judges that cancellation wins: `green_mode` stays low, and the full interval is counted again from that edge.

**Normal-cycle run and the two gap limits.** A run of normal cycles in green mode can meet an edge whose gap sits exactly on a limit. Such a gap either resets the run (gap = BURST) or exits through the short-gap path (gap = NORM). The behavioural reference model, compared every clock, shows which of the two took effect.

// File: rtl/gm_pkg.sv
package gm_pkg;

    typedef enum logic [1:0] {
        GM_ACTIVE   = 2'd0,
        GM_DEBOUNCE = 2'd1,
        GM_GREEN    = 2'd2
    } gm_state_e;

    // One timing set, all values in clock cycles
    typedef struct packed {
        logic [31:0] quiet;
        logic [31:0] settle;
        logic [31:0] burst_gap;
        logic [31:0] norm_per;
    } gm_limits_t;

    // Classification of the current idle gap
    typedef struct packed {
        logic quiet_met;
        logic short_burst;
        logic normal_cyc;
    } gm_gap_class_t;

    function automatic int unsigned gm_max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned gm_bits(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/gm_sat_cnt.sv
module gm_sat_cnt #(
    parameter int unsigned W    = 8,
    parameter int unsigned MAX  = 255,
    parameter int unsigned INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP    = W'(MAX);
    localparam logic [W-1:0] INIT_V = W'(INIT);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            count <= INIT_V;
        end else if (step && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/gm_gap_classify.sv
module gm_gap_classify
    import gm_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   gap,
    input  logic [31:0]    quiet_lim,
    input  logic [31:0]    burst_lim,
    input  logic [31:0]    norm_lim,
    output gm_gap_class_t  cls
);
    logic [31:0] gap_w;

    assign gap_w = 32'(gap);

    always_comb begin
        cls.quiet_met   = gap_w >= quiet_lim;
        cls.normal_cyc  = gap_w < norm_lim;
        cls.short_burst = (gap_w >= norm_lim) && (gap_w < burst_lim);
    end
endmodule

// File: rtl/gm_mode_fsm.sv
module gm_mode_fsm
    import gm_pkg::*;
#(
    parameter int unsigned SW      = 8,
    parameter int unsigned RW      = 3,
    parameter int unsigned RUN_LEN = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_edge,
    input  gm_gap_class_t cls,
    input  logic [31:0]   settle_lim,
    input  logic [SW-1:0] settle_cnt,
    input  logic [RW-1:0] run_cnt,
    output gm_state_e     state_q
);
    gm_state_e state_d;
    logic      settle_done;
    logic      run_done;

    assign settle_done = 32'(settle_cnt) >= (settle_lim - 32'd1);
    assign run_done    = 32'(run_cnt) == 32'(RUN_LEN - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GM_ACTIVE: begin
                if (!sw_edge && cls.quiet_met) state_d = GM_DEBOUNCE;
            end
            GM_DEBOUNCE: begin
                if (sw_edge)          state_d = GM_ACTIVE;
                else if (settle_done) state_d = GM_GREEN;
            end
            GM_GREEN: begin
                if (sw_edge && (cls.short_burst || (cls.normal_cyc && run_done)))
                    state_d = GM_ACTIVE;
            end
            default: state_d = GM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GM_ACTIVE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/gm_burst_green.sv
module gm_burst_green
    import gm_pkg::*;
#(
    parameter int unsigned QUIET_HF  = 4000,
    parameter int unsigned QUIET_LF  = 8000,
    parameter int unsigned SETTLE_HF = 9000,
    parameter int unsigned SETTLE_LF = 16000,
    parameter int unsigned BURST_HF  = 2000,
    parameter int unsigned BURST_LF  = 4000,
    parameter int unsigned NORM_HF   = 1000,
    parameter int unsigned NORM_LF   = 2000,
    parameter int unsigned RUN_LEN   = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_edge,
    input  logic lf_sel,
    output logic green_mode
);
    localparam int unsigned GAP_MAX = gm_max2(gm_max2(QUIET_HF, QUIET_LF),
                                       gm_max2(gm_max2(BURST_HF, BURST_LF),
                                               gm_max2(NORM_HF, NORM_LF)));
    localparam int unsigned GAP_W   = gm_bits(GAP_MAX);
    localparam int unsigned SET_MAX = gm_max2(SETTLE_HF, SETTLE_LF);
    localparam int unsigned SET_W   = gm_bits(SET_MAX);
    localparam int unsigned RUN_W   = gm_bits(RUN_LEN);

    localparam gm_limits_t LIM_HF = '{quiet: QUIET_HF, settle: SETTLE_HF,
                                      burst_gap: BURST_HF, norm_per: NORM_HF};
    localparam gm_limits_t LIM_LF = '{quiet: QUIET_LF, settle: SETTLE_LF,
                                      burst_gap: BURST_LF, norm_per: NORM_LF};

    gm_limits_t         lim;
    gm_gap_class_t      cls;
    gm_state_e          state_q;
    logic [GAP_W-1:0]   gap_cnt;
    logic [SET_W-1:0]   settle_cnt;
    logic [RUN_W-1:0]   run_cnt;
    logic               run_clear;
    logic               run_step;

    assign lim = lf_sel ? LIM_LF : LIM_HF;

    // Clocks since the last edge (reset counts as an edge); saturates
    gm_sat_cnt #(.W(GAP_W), .MAX(GAP_MAX), .INIT(1)) i_gap_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (sw_edge),
        .step  (1'b1),
        .count (gap_cnt)
    );

    // Cycles spent in the settle interval
    gm_sat_cnt #(.W(SET_W), .MAX(SET_MAX), .INIT(0)) i_settle_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (state_q != GM_DEBOUNCE),
        .step  (1'b1),
        .count (settle_cnt)
    );

    assign run_step  = sw_edge && cls.normal_cyc;
    assign run_clear = (state_q != GM_GREEN) || (sw_edge && !cls.normal_cyc);

    // Consecutive normal-period cycles seen in green mode
    gm_sat_cnt #(.W(RUN_W), .MAX(RUN_LEN), .INIT(0)) i_run_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (run_clear),
        .step  (run_step),
        .count (run_cnt)
    );

    gm_gap_classify #(.W(GAP_W)) i_classify (
        .gap       (gap_cnt),
        .quiet_lim (lim.quiet),
        .burst_lim (lim.burst_gap),
        .norm_lim  (lim.norm_per),
        .cls       (cls)
    );

    gm_mode_fsm #(.SW(SET_W), .RW(RUN_W), .RUN_LEN(RUN_LEN)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .sw_edge    (sw_edge),
        .cls        (cls),
        .settle_lim (lim.settle),
        .settle_cnt (settle_cnt),
        .run_cnt    (run_cnt),
        .state_q    (state_q)
    );

    assign green_mode = (state_q == GM_GREEN);
endmodule

// File: rtl/gm_burst_green_chk.sv
module gm_burst_green_chk
    import gm_pkg::*;
#(
    parameter int unsigned GW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          sw_edge,
    input logic          green_mode,
    input gm_state_e     state_q,
    input logic [GW-1:0] gap_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !green_mode);

    // R4
    entry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(green_mode) |-> (!$past(sw_edge) && ($past(state_q) == GM_DEBOUNCE)));

    // R5
    exit_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(green_mode) |-> $past(sw_edge));

    // R8
    gap_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(sw_edge) |-> (gap_q >= $past(gap_q)));

    // R6
    green_quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (green_mode && !sw_edge) |=> green_mode);
endmodule

bind gm_burst_green gm_burst_green_chk #(.GW(GAP_W)) i_gm_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_edge    (sw_edge),
    .green_mode (green_mode),
    .state_q    (state_q),
    .gap_q      (gap_cnt)
);

// File: tb/test_gm_burst_green.sv
`timescale 1ns/1ps
module test_gm_burst_green;
    localparam int QH = 40,  QL = 80;
    localparam int SH = 90,  SL = 160;
    localparam int BH = 20,  BL = 40;
    localparam int NH = 10,  NL = 20;
    localparam int RUN = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_edge = 1'b0;
    logic lf_sel = 1'b0;
    logic green_mode;

    int    checks = 0;
    int    errors = 0;
    int    since  = 0;
    string cur_req = "R1";

    // reference model state
    int cyc = 0, last = 0, run = 0, gap = 0;
    bit in_green = 1'b0, exp_green = 1'b0;

    gm_burst_green #(
        .QUIET_HF(QH), .QUIET_LF(QL), .SETTLE_HF(SH), .SETTLE_LF(SL),
        .BURST_HF(BH), .BURST_LF(BL), .NORM_HF(NH), .NORM_LF(NL), .RUN_LEN(RUN)
    ) i_gm_burst_green (
        .clk(clk), .rst(rst), .sw_edge(sw_edge), .lf_sel(lf_sel), .green_mode(green_mode)
    );

    always #10 clk = ~clk;

    // Behavioural reference: time stamps of edges, no counters of the design
    always @(posedge clk) begin
        int q, s, b, n;
        q = lf_sel ? QL : QH;  s = lf_sel ? SL : SH;
        b = lf_sel ? BL : BH;  n = lf_sel ? NL : NH;
        cyc++;
        if (rst) begin
            last = cyc; in_green = 1'b0; run = 0;
        end else begin
            gap = cyc - last;
            if (sw_edge) begin
                if (in_green) begin
                    if (gap >= n && gap < b) in_green = 1'b0;
                    else if (gap < n) begin
                        run++;
                        if (run == RUN) in_green = 1'b0;
                    end else run = 0;
                end
                last = cyc;
            end else if (!in_green && gap >= q + s) begin
                in_green = 1'b1; run = 0;
            end
        end
        exp_green = in_green;
    end

    always @(negedge clk) begin
        checks++;
        if (green_mode !== exp_green) begin
            errors++;
            $display("FAIL %s model compare: green=%0b expected %0b", cur_req, green_mode, exp_green);
        end
    end

    task automatic look(bit v, string req);
        @(posedge clk);
        #5;
        checks++;
        if (green_mode !== v) begin
            errors++;
            $display("FAIL %s direct check: green=%0b expected %0b", req, green_mode, v);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sw_edge <= 1'b0;
            since++;
        end
    endtask

    // edge whose gap from the previous edge is g clocks
    task automatic kick(int g);
        while (since < g - 1) begin
            @(negedge clk);
            sw_edge <= 1'b0;
            since++;
        end
        @(negedge clk);
        sw_edge <= 1'b1;
        since = 0;
    endtask

    task automatic do_reset(bit lf);
        @(negedge clk);
        rst <= 1'b1; lf_sel <= lf; sw_edge <= 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (green_mode !== 1'b0) begin
            errors++;
            $display("FAIL R1 during reset: green=%0b expected 0", green_mode);
        end
        rst <= 1'b0;
        since = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, green=%0b expected end of test", green_mode);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        do_reset(1'b0);
        look(1'b0, "R1");
        kick(3);

        cur_req = "R2";
        kick(5); kick(5); kick(5);
        idle(QH + 5);
        look(1'b0, "R2");

        cur_req = "R3";
        idle(QH + SH - 1 - (QH + 5));
        look(1'b0, "R3");
        idle(1);
        look(1'b1, "R3");

        cur_req = "R7";
        kick(QH + SH + 20);
        look(1'b1, "R7");

        cur_req = "R5";
        kick(15);
        look(1'b0, "R5");

        cur_req = "R6";
        idle(QH + SH);
        look(1'b1, "R6");
        kick(200);
        for (int i = 0; i < RUN - 1; i++) kick(5);
        look(1'b1, "R6");
        kick(5);
        look(1'b0, "R6");

        cur_req = "R7";
        idle(QH + SH);
        kick(200);
        for (int i = 0; i < 4; i++) kick(5);
        kick(BH);
        look(1'b1, "R7");
        for (int i = 0; i < RUN - 1; i++) kick(5);
        look(1'b1, "R7");
        kick(5);
        look(1'b0, "R7");

        cur_req = "R5";
        idle(QH + SH);
        kick(200);
        kick(NH);
        look(1'b0, "R5");

        cur_req = "R4";
        kick(QH);
        look(1'b0, "R4");
        kick(60);
        look(1'b0, "R4");
        kick(QH + SH);
        look(1'b0, "R4");
        idle(QH + SH - 1);
        look(1'b0, "R4");
        idle(1);
        look(1'b1, "R4");

        cur_req = "R8";
        idle(3000);
        look(1'b1, "R8");
        kick(3001);
        look(1'b1, "R8");
        kick(NH + 1);
        look(1'b0, "R8");

        cur_req = "R9";
        do_reset(1'b1);
        kick(3);
        idle(QH + SH);
        look(1'b0, "R9");
        idle(QL + SL - 1 - (QH + SH));
        look(1'b0, "R9");
        idle(1);
        look(1'b1, "R9");

        cur_req = "R1";
        do_reset(1'b1);
        look(1'b0, "R1");
        kick(3);

        cur_req = "R9";
        idle(QL + SL);
        look(1'b1, "R9");
        kick(300);
        kick(15);
        look(1'b1, "R9");
        kick(30);
        look(1'b0, "R9");

        idle(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule